// File: doc/BRIEF.md
# Descriptor-Chained Memory Copy Channel

This block is one memory-to-memory copy channel driven by a chain of descriptors kept in memory. Software places one or more five-word descriptors in memory, writes the address of the first into the channel, and sets the enable bit. The channel reads the descriptor and copies its block one unit at a time: a single read from the source, then a single write to the destination. When the block is finished, it either moves on to the next descriptor or stops.

Each descriptor gives its own start addresses, transfer widths, address stepping modes and length. A long copy is therefore split into linked blocks of at most 65535 units each. Each block can raise its own completion pulse, and the end of the chain raises a separate pulse. A write-one-to-clear status register holds sticky copies of both events. Clearing the enable bit in the middle of a copy stops the channel cleanly at the next unit boundary.

Top module: `ldma_chain_dma`

## Requirements
- R1: A descriptor is fetched with five 32-bit reads (mem_size = 2) at pointer+0, +4, +8, +12 and +16, in that order. The words are taken as source address, destination address, next pointer, control word and length word.
- R2: Each unit is one read at the source address using the source width code (control bits [6:4]), followed by one write at the destination address using the destination width code (control bits [3:1]). The write carries the data that was read. mem_size carries the width code: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit.
- R3: After each unit, each address is updated by its own mode code: source mode in control bits [10:9], destination mode in bits [8:7]. Code 0 adds the width in bytes, code 1 subtracts it, and codes 2 and 3 leave the address unchanged.
- R4: The block length is bits [15:0] of the length word, and the upper bits are ignored. A length of zero completes the block with no source or destination access.
- R5: The next descriptor is fetched only when control bit 27 or bit 28 is set and the next pointer is nonzero. Otherwise the block ends the chain.
- R6: irq_block pulses for exactly one cycle at the end of each block whose control bit 0 is set, and sets status bit 0.
- R7: At the end of the chain, irq_done pulses for one cycle, status bit 1 is set, the enable bit clears itself and busy falls.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. When a hardware set and a software clear fall in the same cycle, the set wins.
- R9: If the enable bit is cleared during a transfer, the channel finishes the access in progress (at the latest the pending write), goes idle, and raises no interrupt or status flag.
- R10: A request holds its address and direction stable until it is acknowledged. Only one access is outstanding at a time, and no request is made while the channel is idle.
- R11: Register offsets: 0 is control (bit 0 = enable), 1 is the first-descriptor pointer, 2 is status (bit 0 = block, bit 1 = done), and 3 is busy (read only). All of them read zero after reset, except the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address |
| mem_size | output | 2 | Width code of the access |
| mem_wdata | output | 32 | Write data, right-justified |
| mem_ack | input | 1 | Access accepted/completed |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| irq_block | output | 1 | Block-complete pulse |
| irq_done | output | 1 | Chain-complete pulse |
| busy | output | 1 | Channel active |

## Verification
An error in the descriptor word index or the stepping logic shows up at once on mem_addr: it appears in the first access after the faulty state, and in the final destination contents once the block ends. A wrong remaining-unit count changes the number of writes, so it shows up at the end of the block as an early or late irq_block and irq_done pulse. A broken chain decision appears as a wrong count of block pulses. A faulty abort path appears within a few cycles as busy staying high, or as writes continuing after enable is cleared.

// File: rtl/ldma_pkg.sv
package ldma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_RD,
    ST_WR,
    ST_BLK
  } ldma_state_e;

  localparam int DESC_WORDS = 5;
  localparam int CTL_IE     = 0;
  localparam int CTL_DW_LSB = 1;
  localparam int CTL_SW_LSB = 4;
  localparam int CTL_DM_LSB = 7;
  localparam int CTL_SM_LSB = 9;
  localparam int CTL_LINK_D = 27;
  localparam int CTL_LINK_S = 28;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_HEAD = 2'd1;
  localparam logic [1:0] REG_STAT = 2'd2;
  localparam logic [1:0] REG_BUSY = 2'd3;
endpackage

// File: rtl/ldma_step.sv
module ldma_step #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr,
  input  logic [2:0]    width,
  input  logic [1:0]    mode,
  output logic [AW-1:0] nxt
);
  logic [AW-1:0] step;

  always_comb begin
    if (width == 3'd0)      step = AW'(1);
    else if (width == 3'd1) step = AW'(2);
    else                    step = AW'(4);
    case (mode)
      2'd0:    nxt = addr + step;
      2'd1:    nxt = addr - step;
      default: nxt = addr;
    endcase
  end
endmodule

// File: rtl/ldma_regs.sv
module ldma_regs
  import ldma_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          blk_set,
  input  logic          done_set,
  input  logic          busy,
  output logic          en,
  output logic [AW-1:0] head
);
  logic          en_n, blk_f, blk_f_n, done_f, done_f_n;
  logic [AW-1:0] head_n;
  logic          wr_ctrl, wr_head, wr_stat;

  assign wr_ctrl = reg_we && (reg_addr == REG_CTRL);
  assign wr_head = reg_we && (reg_addr == REG_HEAD);
  assign wr_stat = reg_we && (reg_addr == REG_STAT);

  always_comb begin
    en_n     = en;
    head_n   = head;
    if (wr_ctrl)       en_n = reg_wdata[0];
    else if (done_set) en_n = 1'b0;
    if (wr_head)       head_n = reg_wdata[AW-1:0];
    // a hardware set overrides a same-cycle software clear
    blk_f_n  = blk_set  | (blk_f  & ~(wr_stat & reg_wdata[0]));
    done_f_n = done_set | (done_f & ~(wr_stat & reg_wdata[1]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en     <= 1'b0;
      head   <= '0;
      blk_f  <= 1'b0;
      done_f <= 1'b0;
    end else begin
      en     <= en_n;
      head   <= head_n;
      blk_f  <= blk_f_n;
      done_f <= done_f_n;
    end
  end

  always_comb begin
    case (reg_addr)
      REG_CTRL: reg_rdata = {31'd0, en};
      REG_HEAD: reg_rdata = 32'(head);
      REG_STAT: reg_rdata = {30'd0, done_f, blk_f};
      default:  reg_rdata = {31'd0, busy};
    endcase
  end
endmodule

// File: rtl/ldma_engine.sv
module ldma_engine
  import ldma_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LEN_W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [AW-1:0] head,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [1:0]    mem_size,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          blk_set,
  output logic          done_set,
  output logic          busy
);
  localparam int WIDX_W = $clog2(DESC_WORDS);
  localparam logic [WIDX_W-1:0] WIDX_LAST = WIDX_W'(DESC_WORDS - 1);

  ldma_state_e       st, st_n;
  logic [WIDX_W-1:0] widx, widx_n;
  logic [AW-1:0]     dptr, dptr_n, sar, sar_n, dar, dar_n, llp, llp_n;
  logic [31:0]       ctl, ctl_n, dat, dat_n;
  logic [LEN_W-1:0]  rem, rem_n;
  logic              link;

  logic [AW-1:0] cur_a [2];
  logic [AW-1:0] nxt_a [2];
  logic [2:0]    w_a   [2];
  logic [1:0]    m_a   [2];

  always_comb begin
    cur_a[0] = sar;
    cur_a[1] = dar;
    w_a[0]   = ctl[CTL_SW_LSB +: 3];
    w_a[1]   = ctl[CTL_DW_LSB +: 3];
    m_a[0]   = ctl[CTL_SM_LSB +: 2];
    m_a[1]   = ctl[CTL_DM_LSB +: 2];
  end

  // index 0 steps the source address, index 1 the destination address
  for (genvar g = 0; g < 2; g++) begin : g_step
    ldma_step #(.AW(AW)) u_step (
      .addr  (cur_a[g]),
      .width (w_a[g]),
      .mode  (m_a[g]),
      .nxt   (nxt_a[g])
    );
  end

  assign link = (ctl[CTL_LINK_D] | ctl[CTL_LINK_S]) && (llp != '0);
  assign busy = (st != ST_IDLE);

  always_comb begin
    st_n      = st;
    widx_n    = widx;
    dptr_n    = dptr;
    sar_n     = sar;
    dar_n     = dar;
    llp_n     = llp;
    ctl_n     = ctl;
    rem_n     = rem;
    dat_n     = dat;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_size  = 2'd2;
    mem_wdata = dat;
    blk_set   = 1'b0;
    done_set  = 1'b0;
    case (st)
      ST_IDLE: begin
        if (en) begin
          st_n   = ST_FETCH;
          dptr_n = head;
          widx_n = '0;
        end
      end
      ST_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = dptr + AW'({widx, 2'b00});
        if (mem_ack) begin
          case (widx)
            WIDX_W'(0): sar_n = mem_rdata[AW-1:0];
            WIDX_W'(1): dar_n = mem_rdata[AW-1:0];
            WIDX_W'(2): llp_n = mem_rdata[AW-1:0];
            WIDX_W'(3): ctl_n = mem_rdata;
            default:    rem_n = mem_rdata[LEN_W-1:0];
          endcase
          if (!en)                    st_n = ST_IDLE;
          else if (widx == WIDX_LAST) st_n = (mem_rdata[LEN_W-1:0] == '0) ? ST_BLK : ST_RD;
          else                        widx_n = widx + 1'b1;
        end
      end
      ST_RD: begin
        mem_req  = 1'b1;
        mem_addr = sar;
        mem_size = ctl[CTL_SW_LSB +: 2];
        if (mem_ack) begin
          dat_n = mem_rdata;
          st_n  = ST_WR;
        end
      end
      ST_WR: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_addr = dar;
        mem_size = ctl[CTL_DW_LSB +: 2];
        if (mem_ack) begin
          sar_n = nxt_a[0];
          dar_n = nxt_a[1];
          rem_n = rem - 1'b1;
          if (!en)                       st_n = ST_IDLE;
          else if (rem == LEN_W'(1))     st_n = ST_BLK;
          else                           st_n = ST_RD;
        end
      end
      ST_BLK: begin
        if (!en) begin
          st_n = ST_IDLE;
        end else begin
          blk_set = ctl[CTL_IE];
          if (link) begin
            st_n   = ST_FETCH;
            dptr_n = llp;
            widx_n = '0;
          end else begin
            done_set = 1'b1;
            st_n     = ST_IDLE;
          end
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      widx <= '0;
      dptr <= '0;
      sar  <= '0;
      dar  <= '0;
      llp  <= '0;
      ctl  <= '0;
      rem  <= '0;
      dat  <= '0;
    end else begin
      st   <= st_n;
      widx <= widx_n;
      dptr <= dptr_n;
      sar  <= sar_n;
      dar  <= dar_n;
      llp  <= llp_n;
      ctl  <= ctl_n;
      rem  <= rem_n;
      dat  <= dat_n;
    end
  end
endmodule

// File: rtl/ldma_chain_dma.sv
module ldma_chain_dma #(
  parameter int AW    = 32,
  parameter int LEN_W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [1:0]    mem_size,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          irq_block,
  output logic          irq_done,
  output logic          busy
);
  logic          en;
  logic [AW-1:0] head;

  ldma_regs #(.AW(AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .blk_set   (irq_block),
    .done_set  (irq_done),
    .busy      (busy),
    .en        (en),
    .head      (head)
  );

  ldma_engine #(.AW(AW), .LEN_W(LEN_W)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .head      (head),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_size  (mem_size),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .blk_set   (irq_block),
    .done_set  (irq_done),
    .busy      (busy)
  );
endmodule

// File: rtl/ldma_chain_dma_chk.sv
module ldma_chain_dma_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ack,
  input logic          irq_block,
  input logic          irq_done,
  input logic          busy
);
  a_r10_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  a_r2_write_is_request: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_req);

  a_r6_block_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq_block |=> !irq_block);

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done |=> (!irq_done && !busy));
endmodule

bind ldma_chain_dma ldma_chain_dma_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_ack   (mem_ack),
  .irq_block (irq_block),
  .irq_done  (irq_done),
  .busy      (busy)
);

// File: tb/ldma_chain_dma_tb.sv
`timescale 1ns/1ps
module ldma_chain_dma_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we, mem_ack, irq_block, irq_done, busy;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [1:0]  mem_size;

  always #2.5 clk = ~clk;

  ldma_chain_dma u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .irq_block(irq_block), .irq_done(irq_done), .busy(busy)
  );

  logic [7:0]  mem  [4096];
  logic [7:0]  expm [4096];
  logic [31:0] rd_log [8];
  int rd_log_n = 0, wr_cnt = 0, blk_cnt = 0, done_cnt = 0, viol = 0;
  int checks = 0, fails = 0;
  logic        pend = 1'b0;
  logic [31:0] paddr = 32'd0;

  // memory model: single-beat, acknowledged one cycle after the request is seen
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= 32'd0;
    end else begin
      mem_ack <= 1'b0;
      if (mem_req && !mem_ack) begin
        int nb;
        logic [31:0] rv;
        nb = (mem_size == 2'd0) ? 1 : (mem_size == 2'd1) ? 2 : 4;
        mem_ack <= 1'b1;
        if (mem_we) begin
          for (int k = 0; k < nb; k++) mem[(mem_addr + k) & 32'hFFF] <= mem_wdata[8*k +: 8];
          wr_cnt <= wr_cnt + 1;
        end else begin
          rv = 32'd0;
          for (int k = 0; k < nb; k++) rv[8*k +: 8] = mem[(mem_addr + k) & 32'hFFF];
          mem_rdata <= rv;
          if (rd_log_n < 8) begin
            rd_log[rd_log_n] <= mem_addr;
            rd_log_n <= rd_log_n + 1;
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (irq_block) blk_cnt++;
      if (irq_done)  done_cnt++;
      if (pend && (!mem_req || mem_addr != paddr)) viol++;
      pend  = mem_req && !mem_ack;
      paddr = mem_addr;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #0.5 d = reg_rdata;
  endtask

  task automatic wr32(input int a, input logic [31:0] v);
    for (int k = 0; k < 4; k++) mem[(a + k) & 4095] = v[8*k +: 8];
  endtask

  task automatic put_desc(input int d, input int s, input int t, input int l,
                          input logic [31:0] c, input logic [31:0] h);
    wr32(d, s); wr32(d + 4, t); wr32(d + 8, l); wr32(d + 12, c); wr32(d + 16, h);
  endtask

  task automatic fill_mem();
    for (int i = 0; i < 4096; i++) mem[i] = (i >= 12'h800) ? 8'hEE : 8'((i * 7 + 3) & 255);
  endtask

  task automatic start(input int h);
    reg_wr(2'd2, 32'd3);
    reg_wr(2'd1, h);
    blk_cnt = 0; done_cnt = 0; rd_log_n = 0;
    reg_wr(2'd0, 32'd1);
    @(negedge clk);
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 20000) begin
      @(negedge clk);
      n++;
    end
    if (busy) chk(1'b0, "watchdog wait_idle", n, 20000);
  endtask

  function automatic int nbytes(input int w);
    return (w == 0) ? 1 : (w == 1) ? 2 : 4;
  endfunction

  function automatic int stepa(input int a, input int w, input int m);
    if (m == 0) return a + nbytes(w);
    if (m == 1) return a - nbytes(w);
    return a;
  endfunction

  typedef struct packed {
    logic [3:0] nblk;
    logic [7:0] len;
    logic [2:0] sw;
    logic [2:0] dw;
    logic [1:0] sm;
    logic [1:0] dm;
    logic       ie;
  } vec_t;

  localparam int NVEC = 5;
  localparam vec_t VEC [NVEC] = '{
    '{4'd3, 8'd4, 3'd2, 3'd2, 2'd0, 2'd0, 1'b1},
    '{4'd2, 8'd5, 3'd0, 3'd0, 2'd0, 2'd0, 1'b0},
    '{4'd1, 8'd3, 3'd1, 3'd1, 2'd1, 2'd1, 1'b1},
    '{4'd1, 8'd4, 3'd2, 3'd0, 2'd0, 2'd2, 1'b1},
    '{4'd2, 8'd3, 3'd0, 3'd2, 2'd3, 2'd0, 1'b1}
  };

  logic [31:0] rv;
  int w0, mism;

  initial begin : watchdog
    #900000;
    chk(1'b0, "watchdog global", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    fill_mem();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    reg_rd(2'd0, rv); chk(rv == 0, "R11 ctrl after reset", rv, 0);
    reg_rd(2'd2, rv); chk(rv == 0, "R11 status after reset", rv, 0);
    reg_rd(2'd3, rv); chk(rv == 0, "R11 busy after reset", rv, 0);
    chk(!mem_req && !irq_block && !irq_done, "R10 quiet after reset", mem_req, 0);

    // table of scenarios: R2 R3 R5 R6 R7
    for (int v = 0; v < NVEC; v++) begin
      vec_t t;
      t = VEC[v];
      fill_mem();
      for (int b = 0; b < int'(t.nblk); b++) begin
        int d, s, o;
        logic [31:0] c;
        d = 32'h100 + 20 * b;
        s = 32'h400 + 32'h80 * b + ((t.sm == 2'd1) ? 32'h7C : 0);
        o = 32'h800 + 32'h80 * b + ((t.dm == 2'd1) ? 32'h7C : 0);
        c = 32'(t.ie) | (32'(t.dw) << 1) | (32'(t.sw) << 4) | (32'(t.dm) << 7) | (32'(t.sm) << 9);
        if (b < int'(t.nblk) - 1) c = c | (32'd1 << 28);
        put_desc(d, s, o, (b < int'(t.nblk) - 1) ? d + 20 : 0, c, 32'(t.len));
      end
      for (int i = 0; i < 4096; i++) expm[i] = mem[i];
      for (int b = 0; b < int'(t.nblk); b++) begin
        int s, o;
        logic [31:0] val;
        s = 32'h400 + 32'h80 * b + ((t.sm == 2'd1) ? 32'h7C : 0);
        o = 32'h800 + 32'h80 * b + ((t.dm == 2'd1) ? 32'h7C : 0);
        for (int u = 0; u < int'(t.len); u++) begin
          val = 32'd0;
          for (int k = 0; k < nbytes(int'(t.sw)); k++) val[8*k +: 8] = expm[(s + k) & 4095];
          for (int k = 0; k < nbytes(int'(t.dw)); k++) expm[(o + k) & 4095] = val[8*k +: 8];
          s = stepa(s, int'(t.sw), int'(t.sm));
          o = stepa(o, int'(t.dw), int'(t.dm));
        end
      end
      start(32'h100);
      wait_idle();
      repeat (2) @(negedge clk);
      mism = 0;
      for (int i = 0; i < 4096; i++) if (mem[i] !== expm[i]) mism++;
      chk(mism == 0, $sformatf("R2/R3 row %0d data, R2 R3 mismatching bytes", v), mism, 0);
      chk(blk_cnt == (t.ie ? int'(t.nblk) : 0), $sformatf("R6 R5 row %0d block pulses", v),
          blk_cnt, t.ie ? int'(t.nblk) : 0);
      chk(done_cnt == 1, $sformatf("R7 row %0d done pulses", v), done_cnt, 1);
      reg_rd(2'd2, rv);
      chk(rv == {30'd0, 1'b1, t.ie}, $sformatf("R7 R6 row %0d status", v), rv, {30'd0, 1'b1, t.ie});
      reg_rd(2'd0, rv);
      chk(rv == 0, $sformatf("R7 row %0d enable self-clear", v), rv, 0);
    end

    // R4 zero length, R1 fetch order
    fill_mem();
    put_desc(32'h200, 32'h400, 32'h800, 0, 32'h1 | (32'd2 << 1) | (32'd2 << 4), 32'd0);
    w0 = wr_cnt;
    start(32'h200);
    wait_idle();
    chk(wr_cnt == w0, "R4 zero length no writes", wr_cnt - w0, 0);
    chk(blk_cnt == 1 && done_cnt == 1, "R4 zero length pulses", blk_cnt * 10 + done_cnt, 11);
    chk(rd_log_n == 5, "R4 zero length reads only descriptor", rd_log_n, 5);
    for (int i = 0; i < 5; i++)
      chk(rd_log[i] == 32'h200 + 4 * i, "R1 descriptor word address", rd_log[i], 32'h200 + 4 * i);

    // R4 upper length bits ignored
    put_desc(32'h200, 32'h400, 32'h800, 0, (32'd2 << 1) | (32'd2 << 4), 32'h0003_0002);
    w0 = wr_cnt;
    start(32'h200);
    wait_idle();
    chk(wr_cnt - w0 == 2, "R4 length uses low 16 bits", wr_cnt - w0, 2);

    // R5 link via bit 27, then link bits clear with nonzero pointer
    put_desc(32'h200, 32'h400, 32'h800, 32'h220, 32'h1 | (32'd1 << 27), 32'd3);
    put_desc(32'h220, 32'h440, 32'h840, 32'h200, 32'h1, 32'd2);
    w0 = wr_cnt;
    start(32'h200);
    wait_idle();
    chk(blk_cnt == 2, "R5 chain stops without link bits", blk_cnt, 2);
    chk(wr_cnt - w0 == 5, "R5 units over both blocks", wr_cnt - w0, 5);

    // R8 write-one-to-clear
    reg_wr(2'd2, 32'd1);
    reg_rd(2'd2, rv); chk(rv == 32'd2, "R8 clear block flag only", rv, 2);
    reg_wr(2'd2, 32'd2);
    reg_rd(2'd2, rv); chk(rv == 32'd0, "R8 clear done flag", rv, 0);

    // R9 abort
    put_desc(32'h200, 32'h400, 32'h800, 0, 32'h1 | (32'd2 << 1) | (32'd2 << 4), 32'd60);
    w0 = wr_cnt;
    start(32'h200);
    for (int n = 0; n < 2000 && (wr_cnt - w0) < 5; n++) @(negedge clk);
    reg_wr(2'd0, 32'd0);
    repeat (6) @(negedge clk);
    chk(!busy, "R9 idle after abort", busy, 0);
    w0 = wr_cnt;
    repeat (10) @(negedge clk);
    chk(wr_cnt == w0, "R9 no writes after abort", wr_cnt - w0, 0);
    chk(blk_cnt == 0 && done_cnt == 0, "R9 no pulses on abort", blk_cnt + done_cnt, 0);
    reg_rd(2'd2, rv); chk(rv == 0, "R9 no status on abort", rv, 0);

    chk(viol == 0, "R10 request held until ack", viol, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule